// File: doc/BRIEF.md
# BCD Calendar Clock with Update Handshake

A register-mapped time-of-day and date keeper. Seconds, minutes and hours (24-hour only) sit in one 32-bit word, and century, year, month, day-of-week and day-of-month sit in another. Every field is packed BCD. The clock advances once for each pulse on a one-second strobe input. Seconds roll into minutes, minutes into hours, and midnight into the next day. The day-of-month follows each month's length. February has 29 days when the two-digit year is a multiple of 4. December rolls into January of the next year, and year 99 carries into the century.

Software changes the time by setting halt bits in a control word. Each halt bit freezes its counter at once. A status flag then confirms that the stop has taken effect. The block refuses to confirm a second stop until a one-second strobe has been seen since the previous confirmation. Every value written while halted is checked. A bad value is not loaded and sets a flag in a validity word. While that flag is set, the matching counter holds. A sticky event word records strobes, minute changes and day changes. An enable/disable pair of mask registers gates these events onto one interrupt line.

Register word offsets (byte address): 0x00 control, 0x04 time, 0x08 calendar, 0x0C events (read), 0x10 event clear, 0x14 interrupt enable, 0x18 interrupt disable, 0x1C interrupt mask (read), 0x20 validity (read).

Top module: `bcd_rtc`

## Requirements
- R1: Out of reset: time reads 0x00000000, calendar reads 0x01210019 (century 19, year 00, month 01, day-of-week 1, day 01), and events, validity, interrupt mask and irq_o are all zero.
- R2: Time layout is seconds [6:0], minutes [14:8], hours [21:16], with other bits reading 0. Each strobe while running adds one second, with BCD carry 59→00 into minutes and hours, and 23:59:59 becomes 00:00:00.
- R3: Calendar layout is century [6:0], year [15:8], month [20:16], day-of-week [23:21] (1..7), day [29:24]. A midnight carry advances day-of-week 7→1 and the day by month length (Feb 29 when year%4==0, else 28; Apr/Jun/Sep/Nov 30), then month 12→01 with year+1, then year 99→00 with century+1.
- R4: Control bit 0 halts the time counter and bit 1 halts the calendar, from the cycle after the write. Strobes then change nothing. Clearing a bit resumes counting from the held or loaded value.
- R5: Event bit 0 (update acknowledge) sets one cycle after a halt bit becomes set, if a strobe has occurred since the last acknowledge or since reset. Otherwise it sets one cycle after the next strobe. It sets only once per request.
- R6: A write to the time word is ignored unless control bit 0 is set, and a write to the calendar word is ignored unless control bit 1 is set.
- R7: An accepted time write with a non-BCD digit, seconds or minutes above 59, or hours above 23 sets validity bit 0 and leaves the time unchanged. A legal accepted write loads the value and clears bit 0.
- R8: An accepted calendar write with a non-BCD century or year, a month outside 1..12, a day-of-week of 0, or a day outside 1..month length sets validity bit 1 and is not loaded. An all-zero word is illegal. A legal write loads and clears bit 1. Validity bits 2 and 3 read 0.
- R9: While validity bit 0 (or bit 1) is set, the time (or calendar) holds even when it is not halted.
- R10: Event bit 2 sets on every strobe. Bit 3 sets when the running time moves from second 59 to 00. Bit 4 sets when the running calendar takes a day carry. Bit 1 never sets. A set wins over a clear in the same cycle.
- R11: Writing the event-clear word clears each event bit whose data bit is 1, in the cycle after the write.
- R12: Writing the enable word sets mask bits and writing the disable word clears them (a write of all ones clears all of them). The mask word reads the set. irq_o is high whenever a masked event bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt, OR of enabled events |

## Verification
The two functions that collide are a one-second strobe setting an event bit and a software clear of that same bit. The bench drives tick_i and an event-clear write in the same clock cycle, and expects the bit to stay set. A second collision is a strobe that arrives while an update request waits for its acknowledge. The bench checks that the acknowledge is withheld, appears exactly one cycle after that strobe, and that the strobe itself moved no counter.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned N_EVT   = 5;
  localparam int unsigned EV_ACK  = 0;
  localparam int unsigned EV_ALM  = 1;
  localparam int unsigned EV_SEC  = 2;
  localparam int unsigned EV_TIM  = 3;
  localparam int unsigned EV_CAL  = 4;

  // word index = byte address / 4
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_TIME  = 1;
  localparam int unsigned A_CAL   = 2;
  localparam int unsigned A_STAT  = 3;
  localparam int unsigned A_SCLR  = 4;
  localparam int unsigned A_IEN   = 5;
  localparam int unsigned A_IDIS  = 6;
  localparam int unsigned A_IMASK = 7;
  localparam int unsigned A_VALID = 8;

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_time.sv
module bcd_rtc_time
  import bcd_rtc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        run_i,
  input  logic        wr_i,
  input  logic [6:0]  w_sec_i,
  input  logic [6:0]  w_min_i,
  input  logic [5:0]  w_hr_i,
  output logic [31:0] time_o,
  output logic        bad_o,
  output logic        min_evt_o,
  output logic        day_carry_o
);
  logic [7:0] sec_q, min_q, hr_q;
  logic       bad_q;
  logic [7:0] w_sec, w_min, w_hr;
  logic       w_ok, step;

  assign w_sec = {1'b0, w_sec_i};
  assign w_min = {1'b0, w_min_i};
  assign w_hr  = {2'b00, w_hr_i};
  assign w_ok  = bcd_ok(w_sec) && (w_sec <= 8'h59) &&
                 bcd_ok(w_min) && (w_min <= 8'h59) &&
                 bcd_ok(w_hr)  && (w_hr  <= 8'h23);

  assign step        = tick_i & run_i & ~bad_q;
  assign min_evt_o   = step & (sec_q == 8'h59);
  assign day_carry_o = min_evt_o & (min_q == 8'h59) & (hr_q == 8'h23);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      bad_q <= 1'b0;
    end else if (wr_i) begin
      bad_q <= ~w_ok;
      if (w_ok) begin
        sec_q <= w_sec;
        min_q <= w_min;
        hr_q  <= w_hr;
      end
    end else if (step) begin
      if (sec_q != 8'h59) begin
        sec_q <= bcd_inc(sec_q);
      end else begin
        sec_q <= '0;
        if (min_q != 8'h59) begin
          min_q <= bcd_inc(min_q);
        end else begin
          min_q <= '0;
          hr_q  <= (hr_q == 8'h23) ? 8'h00 : bcd_inc(hr_q);
        end
      end
    end
  end

  assign time_o = {10'b0, hr_q[5:0], 1'b0, min_q[6:0], 1'b0, sec_q[6:0]};
  assign bad_o  = bad_q;
endmodule

// File: rtl/bcd_rtc_cal.sv
module bcd_rtc_cal
  import bcd_rtc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        carry_i,
  input  logic        run_i,
  input  logic        wr_i,
  input  logic [6:0]  w_cen_i,
  input  logic [7:0]  w_yr_i,
  input  logic [4:0]  w_mon_i,
  input  logic [2:0]  w_dow_i,
  input  logic [5:0]  w_day_i,
  output logic [31:0] cal_o,
  output logic        bad_o,
  output logic        day_evt_o
);
  logic [7:0] cen_q, yr_q, mon_q, day_q;
  logic [2:0] dow_q;
  logic       bad_q;
  logic [7:0] w_cen, w_mon, w_day, cur_len;
  logic       w_ok, step;

  assign w_cen = {1'b0, w_cen_i};
  assign w_mon = {3'b000, w_mon_i};
  assign w_day = {2'b00, w_day_i};
  assign w_ok  = bcd_ok(w_cen) && bcd_ok(w_yr_i) &&
                 bcd_ok(w_mon) && (w_mon >= 8'h01) && (w_mon <= 8'h12) &&
                 (w_dow_i != 3'd0) &&
                 bcd_ok(w_day) && (w_day >= 8'h01) &&
                 (w_day <= month_len(w_mon, is_leap(w_yr_i)));

  assign cur_len   = month_len(mon_q, is_leap(yr_q));
  assign step      = carry_i & run_i & ~bad_q;
  assign day_evt_o = step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q <= 8'h19;
      yr_q  <= 8'h00;
      mon_q <= 8'h01;
      day_q <= 8'h01;
      dow_q <= 3'd1;
      bad_q <= 1'b0;
    end else if (wr_i) begin
      bad_q <= ~w_ok;
      if (w_ok) begin
        cen_q <= w_cen;
        yr_q  <= w_yr_i;
        mon_q <= w_mon;
        day_q <= w_day;
        dow_q <= w_dow_i;
      end
    end else if (step) begin
      dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (day_q != cur_len) begin
        day_q <= bcd_inc(day_q);
      end else begin
        day_q <= 8'h01;
        if (mon_q != 8'h12) begin
          mon_q <= bcd_inc(mon_q);
        end else begin
          mon_q <= 8'h01;
          if (yr_q != 8'h99) begin
            yr_q <= bcd_inc(yr_q);
          end else begin
            yr_q  <= 8'h00;
            cen_q <= (cen_q == 8'h99) ? 8'h00 : bcd_inc(cen_q);
          end
        end
      end
    end
  end

  assign cal_o = {2'b00, day_q[5:0], dow_q, mon_q[4:0], yr_q, 1'b0, cen_q[6:0]};
  assign bad_o = bad_q;
endmodule

// File: rtl/bcd_rtc_evt.sv
module bcd_rtc_evt #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s_q, m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= 1'b0;
        m_q <= 1'b0;
      end else begin
        s_q <= set_i[i] | (s_q & ~clr_i[i]);  // set wins
        m_q <= en_i[i]  | (m_q & ~dis_i[i]);
      end
    end
    assign stat_o[i] = s_q;
    assign mask_o[i] = m_q;
  end

  assign irq_o = |(stat_o & mask_o);
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       ctrl_q;
  logic             armed_q, served_q, set_ack;
  logic             tim_we, cal_we;
  logic             tim_bad, cal_bad, min_evt, day_carry, day_evt;
  logic [31:0]      time_w, cal_w;
  logic [N_EVT-1:0] set_v, clr_v, en_v, dis_v, stat_w, mask_w;
  logic [3:0]       valid_w;
  logic             unused_bits;

  assign idx         = addr_i[ADDR_W-1:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:30]};

  assign tim_we = wr_i && (idx == IDX_W'(A_TIME)) && ctrl_q[0];
  assign cal_we = wr_i && (idx == IDX_W'(A_CAL))  && ctrl_q[1];

  // acknowledge once per request, only after a strobe since the last one
  assign set_ack = (|ctrl_q) & armed_q & ~served_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= 2'b00;
      armed_q  <= 1'b1;
      served_q <= 1'b0;
    end else begin
      if (wr_i && (idx == IDX_W'(A_CTRL))) ctrl_q <= wdata_i[1:0];
      if (set_ack)     armed_q <= 1'b0;
      else if (tick_i) armed_q <= 1'b1;
      if (!(|ctrl_q))  served_q <= 1'b0;
      else if (set_ack) served_q <= 1'b1;
    end
  end

  bcd_rtc_time u_time (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .run_i       (~ctrl_q[0]),
    .wr_i        (tim_we),
    .w_sec_i     (wdata_i[6:0]),
    .w_min_i     (wdata_i[14:8]),
    .w_hr_i      (wdata_i[21:16]),
    .time_o      (time_w),
    .bad_o       (tim_bad),
    .min_evt_o   (min_evt),
    .day_carry_o (day_carry)
  );

  bcd_rtc_cal u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .carry_i   (day_carry),
    .run_i     (~ctrl_q[1]),
    .wr_i      (cal_we),
    .w_cen_i   (wdata_i[6:0]),
    .w_yr_i    (wdata_i[15:8]),
    .w_mon_i   (wdata_i[20:16]),
    .w_dow_i   (wdata_i[23:21]),
    .w_day_i   (wdata_i[29:24]),
    .cal_o     (cal_w),
    .bad_o     (cal_bad),
    .day_evt_o (day_evt)
  );

  always_comb begin
    set_v         = '0;
    set_v[EV_ACK] = set_ack;
    set_v[EV_ALM] = 1'b0;
    set_v[EV_SEC] = tick_i;
    set_v[EV_TIM] = min_evt;
    set_v[EV_CAL] = day_evt;
  end

  assign clr_v = (wr_i && (idx == IDX_W'(A_SCLR))) ? wdata_i[N_EVT-1:0] : '0;
  assign en_v  = (wr_i && (idx == IDX_W'(A_IEN)))  ? wdata_i[N_EVT-1:0] : '0;
  assign dis_v = (wr_i && (idx == IDX_W'(A_IDIS))) ? wdata_i[N_EVT-1:0] : '0;

  bcd_rtc_evt #(.N(N_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .en_i   (en_v),
    .dis_i  (dis_v),
    .stat_o (stat_w),
    .mask_o (mask_w),
    .irq_o  (irq_o)
  );

  assign valid_w = {2'b00, cal_bad, tim_bad};

  always_comb begin
    rdata_o = '0;
    case (idx)
      IDX_W'(A_CTRL):  rdata_o = {30'b0, ctrl_q};
      IDX_W'(A_TIME):  rdata_o = time_w;
      IDX_W'(A_CAL):   rdata_o = cal_w;
      IDX_W'(A_STAT):  rdata_o = {{(32-N_EVT){1'b0}}, stat_w};
      IDX_W'(A_IMASK): rdata_o = {{(32-N_EVT){1'b0}}, mask_w};
      IDX_W'(A_VALID): rdata_o = {28'b0, valid_w};
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic [1:0]  ctrl,
  input logic        tim_we,
  input logic        cal_we,
  input logic [31:0] time_w,
  input logic [31:0] cal_w,
  input logic [3:0]  bad,
  input logic [4:0]  stat,
  input logic [4:0]  mask,
  input logic        irq_o
);
  assert_time_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[0] && !tim_we |=> $stable(time_w));

  assert_cal_halt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[1] && !cal_we |=> $stable(cal_w));

  assert_ack_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[0]) |-> $past(ctrl) != 2'b00);

  assert_bad_time_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad[0] && !tim_we |=> $stable(time_w));

  assert_sec_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> stat[2]);

  assert_time_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad[0] |-> (time_w[6:0] <= 7'h59) && (time_w[14:8] <= 7'h59) && (time_w[21:16] <= 6'h23));

  assert_cal_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad[1] |-> (cal_w[29:24] != 6'h00) && (cal_w[20:16] != 5'h00) && (cal_w[20:16] <= 5'h12));

  assert_irq_masked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask == 5'b0 |-> !irq_o);
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .ctrl   (ctrl_q),
  .tim_we (tim_we),
  .cal_we (cal_we),
  .time_w (time_w),
  .cal_w  (cal_w),
  .bad    (valid_w),
  .stat   (stat_w),
  .mask   (mask_w),
  .irq_o  (irq_o)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
  localparam logic [5:0] CTRL = 6'h00, TIME = 6'h04, CAL = 6'h08, STAT = 6'h0C,
                         SCLR = 6'h10, IEN = 6'h14, IDIS = 6'h18, IMASK = 6'h1C,
                         VALID = 6'h20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mh, mm, ms, mc, my, mo, md, mw;

  always #10 clk = ~clk;

  bcd_rtc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] tobcd(input int n);
    return 32'(((n / 10) << 4) | (n % 10));
  endfunction
  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [31:0] pk_time(input int h, input int m, input int s);
    return (tobcd(h) << 16) | (tobcd(m) << 8) | tobcd(s);
  endfunction
  function automatic logic [31:0] pk_cal(input int c, input int y, input int mon,
                                         input int dw, input int d);
    return (tobcd(d) << 24) | (32'(dw) << 21) | (tobcd(mon) << 16) | (tobcd(y) << 8) | tobcd(c);
  endfunction

  task automatic model_tick();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mw = (mw % 7) + 1;
          md++;
          if (md > mdays(mo, my)) begin
            md = 1; mo++;
            if (mo > 12) begin
              mo = 1; my++;
              if (my > 99) begin my = 0; mc = (mc + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask
  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask
  task automatic tick();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rchk(input string tag, input string what, input logic [5:0] a,
                      input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, what, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    rchk("R1", "time", TIME, 32'h0);
    rchk("R1", "cal", CAL, 32'h01210019);
    rchk("R1", "stat", STAT, 32'h0);
    rchk("R1", "valid", VALID, 32'h0);
    rchk("R1", "mask", IMASK, 32'h0);
    check("R1", "irq", {31'b0, irq_o}, 32'h0);

    // R2 / R10 / R11 one strobe, then clear
    tick();
    rchk("R2", "one second", TIME, 32'h1);
    rchk("R10", "sec event", STAT, 32'h04);
    wr(SCLR, 32'h04);
    rchk("R11", "w1c", STAT, 32'h0);

    // R6 write while running is ignored
    wr(TIME, 32'h00123456);
    rchk("R6", "time ignored", TIME, 32'h1);
    wr(CAL, 32'h28622420);
    rchk("R6", "cal ignored", CAL, 32'h01210019);

    // R5 ack / R4 halt
    wr(CTRL, 32'h1);
    idle(1);
    rchk("R5", "ack", STAT, 32'h01);
    tick();
    rchk("R4", "halted time", TIME, 32'h1);
    wr(TIME, 32'h00235959);
    rchk("R7", "load", TIME, 32'h00235959);
    wr(TIME, 32'h00006000);
    rchk("R7", "bad sec flag", VALID, 32'h1);
    rchk("R7", "bad sec kept", TIME, 32'h00235959);
    wr(TIME, 32'h00240000);
    rchk("R7", "bad hour flag", VALID, 32'h1);
    wr(TIME, 32'h0023595A);
    rchk("R7", "non-bcd flag", VALID, 32'h1);
    wr(TIME, 32'h00235959);
    rchk("R7", "flag cleared", VALID, 32'h0);

    // R8 calendar validation, leap day
    wr(CTRL, 32'h3);
    wr(CAL, 32'h28622420);
    rchk("R8", "load", CAL, 32'h28622420);
    wr(CAL, 32'h0);
    rchk("R8", "zero flag", VALID, 32'h2);
    rchk("R8", "zero kept", CAL, 32'h28622420);
    wr(CAL, 32'h30622320);  // Feb 30 in 2023
    rchk("R8", "feb30 flag", VALID, 32'h2);
    wr(CAL, 32'h29622320);  // Feb 29 in non-leap 2023
    rchk("R8", "feb29 nonleap flag", VALID, 32'h2);
    wr(CAL, 32'h28622420);
    rchk("R8", "flag cleared", VALID, 32'h0);
    wr(CTRL, 32'h0);
    wr(SCLR, 32'h1F);
    tick();
    rchk("R2", "midnight", TIME, 32'h0);
    rchk("R3", "leap day", CAL, 32'h29822420);
    rchk("R10", "all events", STAT, 32'h1C);
    wr(SCLR, 32'h1F);

    // R5 ack withheld until a strobe
    wr(CTRL, 32'h3);
    idle(1);
    rchk("R5", "ack armed", STAT, 32'h01);
    wr(SCLR, 32'h01);
    wr(CTRL, 32'h0);
    wr(CTRL, 32'h3);
    idle(2);
    rchk("R5", "ack withheld", STAT, 32'h0);
    tick();
    rchk("R5", "no ack at strobe", STAT, 32'h04);
    rchk("R4", "strobe during halt", TIME, 32'h0);
    idle(1);
    rchk("R5", "ack after strobe", STAT, 32'h05);
    wr(TIME, 32'h00235959);
    wr(CAL, 32'h31F29920);
    wr(CTRL, 32'h0);
    tick();
    rchk("R3", "century roll", CAL, 32'h01210021);
    rchk("R2", "midnight 2", TIME, 32'h0);

    // R4 calendar-only halt
    wr(CTRL, 32'h3);
    wr(TIME, 32'h00235959);
    wr(CTRL, 32'h2);
    wr(SCLR, 32'h1F);
    tick();
    rchk("R4", "time runs", TIME, 32'h0);
    rchk("R4", "cal frozen", CAL, 32'h01210021);
    rchk("R10", "no cal event", STAT, 32'h0C);

    // R9 bad calendar holds while running
    wr(CTRL, 32'h3);
    wr(CAL, 32'h0);
    wr(TIME, 32'h00235959);
    wr(CTRL, 32'h0);
    tick();
    rchk("R9", "time runs", TIME, 32'h0);
    rchk("R9", "cal holds", CAL, 32'h01210021);
    rchk("R9", "flag", VALID, 32'h2);
    wr(CTRL, 32'h2);
    wr(CAL, 32'h01210021);
    wr(CTRL, 32'h0);
    rchk("R8", "recovered", VALID, 32'h0);

    // R12 interrupts
    wr(SCLR, 32'h1F);
    wr(IEN, 32'h04);
    rchk("R12", "mask", IMASK, 32'h04);
    check("R12", "irq idle", {31'b0, irq_o}, 32'h0);
    tick();
    check("R12", "irq on", {31'b0, irq_o}, 32'h1);
    wr(IDIS, 32'hFFFFFFFF);
    rchk("R12", "mask off", IMASK, 32'h0);
    check("R12", "irq off", {31'b0, irq_o}, 32'h0);

    // R10 strobe and clear in one cycle
    wr(SCLR, 32'h1F);
    tick_i = 1'b1; wr_i = 1'b1; addr_i = SCLR; wdata_i = 32'h04;
    @(negedge clk);
    tick_i = 1'b0; wr_i = 1'b0;
    rchk("R10", "set beats clear", STAT, 32'h0C & 32'h04);

    // R2 / R3 random loads near rollovers
    for (int it = 0; it < 40; it++) begin
      mc = 19 + int'($urandom % 2);
      my = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
      mo = ($urandom % 3 == 0) ? 12 : 1 + int'($urandom % 12);
      md = mdays(mo, my) - int'($urandom % 2);
      mw = 1 + int'($urandom % 7);
      mh = 23 - int'($urandom % 2);
      mm = 59 - int'($urandom % 2);
      ms = 59 - int'($urandom % 3);
      wr(CTRL, 32'h3);
      wr(TIME, pk_time(mh, mm, ms));
      wr(CAL, pk_cal(mc, my, mo, mw, md));
      wr(CTRL, 32'h0);
      rchk("R8", "random load valid", VALID, 32'h0);
      for (int k = 0; k < 1 + int'($urandom % 4); k++) begin
        idle(int'($urandom % 3));
        tick();
        model_tick();
        rchk("R2", "random time", TIME, pk_time(mh, mm, ms));
        rchk("R3", "random cal", CAL, pk_cal(mc, my, mo, mw, md));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule